// File: doc/BRIEF.md
# Parallel Flash Byte Program Controller

This block writes a single byte into a parallel NOR flash that takes its commands as a series of bus writes. A host hands it a target address and a data byte through a valid/ready port. The controller runs the whole operation by itself. It first issues three fixed command writes that open the device for programming, then the byte write itself. It then watches the device's busy indication and finally reads the location back to confirm the stored value.

On the flash side the block drives chip enable, output enable and write enable, all active low. It also drives the address bus, the outgoing data and a data-drive enable that steers an external bidirectional pad. Every bus access has a setup phase, a strobe phase and a hold phase. Each phase length is a parameter counted in clock cycles.

While the device is busy, the device flips data bit 6 on every status read. The controller repeats status reads until two reads in a row agree on that bit. If that does not happen within a parameterised number of reads, it gives up and reports a timeout. A one-cycle `done` pulse ends each operation, and two error flags describe how it ended.

Top module: `flash_prog_ctrl`

## Requirements
- R1: While reset is held and right after it is released, chip enable, write enable and output enable are high, the data-drive enable is low, `req_ready` is 1, `done` is 0 and both error flags are 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only when the controller is idle. A `req_valid` raised while the controller is busy leaves the bus activity and the outcome unchanged.
- R3: A taken request produces exactly four write accesses in this order:
  - address 0x5555 with data 0xAA;
  - address 0x2AAA with data 0x55;
  - address 0x5555 with data 0xA0;
  - the requested address with the requested data.
  Address bits above bit 14 are zero in the first three writes.
- R4: A write access holds chip enable low for SETUP_CLKS+WE_CLKS+HOLD_CLKS cycles. Write enable is low for the WE_CLKS middle cycles. The data drive is enabled for the whole access, and output enable stays high.
- R5: A read access holds chip enable low for SETUP_CLKS+RD_CLKS+HOLD_CLKS cycles. Output enable is low for the RD_CLKS middle cycles, and the data drive stays off. The data bus is sampled on the clock edge that ends the output-enable pulse.
- R6: Chip enable is high for exactly one cycle between consecutive accesses.
- R7: After the fourth write, status reads of the requested address repeat until a read's bit 6 equals the previous read's bit 6. One more read of the requested address then serves as the verify read.
- R8: If POLL_LIMIT status reads pass without two consecutive equal bit-6 values, the operation ends with `err_timeout` set and no verify read.
- R9: `err_verify` is set when the verify read differs from the requested byte in any bit.
- R10: `done` is high for exactly one cycle, the first cycle in which `req_ready` is 1 again. The error flags are valid in that cycle and hold until the next request is taken.
- R11: Only bit 6 decides whether polling has ended. Differences in the other bits between consecutive status reads do not prolong polling or end it early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host asks for a byte program |
| req_ready | output | 1 | Controller idle; request taken when both are high |
| req_addr | input | ADDR_W | Target flash address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle pulse at the end of an operation |
| err_timeout | output | 1 | Polling ran out of reads |
| err_verify | output | 1 | Readback differed from the requested byte |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | 8 | Data driven towards the flash |
| fl_dq_oe | output | 1 | Enables the data pad driver |
| fl_dq_in | input | 8 | Data returned by the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The hardest situation to reach from the ports is the exact end of polling. The first matching pair of bit-6 values can fall on the transition from toggling data to the stored byte, and that pair may differ in the other bits. The same goes for the read on which the timeout limit is reached.

The bench contains a behavioural flash. It recognises the command writes on the rising edge of write enable, then returns a toggling bit 6 for a chosen number of reads while the low bits count upward, and then returns a chosen stored byte. Varying that read count and the stored byte places the first matching pair at each of these boundaries, and also past the limit.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    localparam int UNLOCK_AW = 15;
    localparam logic [UNLOCK_AW-1:0] CMD_ADDR_A = 15'h5555;
    localparam logic [UNLOCK_AW-1:0] CMD_ADDR_B = 15'h2AAA;
    localparam logic [7:0] CMD_KEY_1 = 8'hAA;
    localparam logic [7:0] CMD_KEY_2 = 8'h55;
    localparam logic [7:0] CMD_PROG  = 8'hA0;
    localparam int STATUS_BIT = 6;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_WR_GO,
        CS_WR_WAIT,
        CS_POLL_GO,
        CS_POLL_WAIT,
        CS_CHK_GO,
        CS_CHK_WAIT
    } ctl_e;

    typedef struct packed {
        logic       is_read;
        logic [7:0] wdata;
    } bus_op_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // Command writes 0..2 carry fixed data; index 3 is the payload write.
    function automatic logic [7:0] cmd_data(input logic [1:0] idx);
        case (idx)
            2'd0:    return CMD_KEY_1;
            2'd1:    return CMD_KEY_2;
            default: return CMD_PROG;
        endcase
    endfunction

    function automatic logic [UNLOCK_AW-1:0] cmd_addr(input logic [1:0] idx);
        return (idx == 2'd1) ? CMD_ADDR_B : CMD_ADDR_A;
    endfunction

endpackage

// File: rtl/flash_bus_phy.sv
module flash_bus_phy
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int SETUP_CLKS = 1,
    parameter int WE_CLKS    = 3,
    parameter int RD_CLKS    = 3,
    parameter int HOLD_CLKS  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  bus_op_t           op,
    input  logic [ADDR_W-1:0] addr,
    output logic              fin,
    output logic [7:0]        rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_dout,
    output logic              bus_doe,
    input  logic [7:0]        bus_din,
    output logic              bus_ce_n,
    output logic              bus_oe_n,
    output logic              bus_we_n
);

    localparam int MAXC  = max4(SETUP_CLKS, WE_CLKS, RD_CLKS, HOLD_CLKS);
    localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);

    phase_e            ph;
    logic [CNT_W-1:0]  cnt;
    bus_op_t           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        rdata_q;
    logic              last;

    assign last = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            op_q    <= '0;
            addr_q  <= '0;
            rdata_q <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph     <= PH_SETUP;
                        cnt    <= CNT_W'(SETUP_CLKS - 1);
                        op_q   <= op;
                        addr_q <= addr;
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        ph  <= PH_STROBE;
                        cnt <= op_q.is_read ? CNT_W'(RD_CLKS - 1) : CNT_W'(WE_CLKS - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (last) begin
                        ph  <= PH_HOLD;
                        cnt <= CNT_W'(HOLD_CLKS - 1);
                        if (op_q.is_read) rdata_q <= bus_din;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (last) ph <= PH_IDLE;
                    else      cnt <= cnt - 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign fin      = (ph == PH_HOLD) && last;
    assign rdata    = rdata_q;
    assign bus_addr = addr_q;
    assign bus_dout = op_q.wdata;
    assign bus_ce_n = (ph == PH_IDLE);
    assign bus_doe  = (ph != PH_IDLE) && !op_q.is_read;
    assign bus_we_n = !((ph == PH_STROBE) && !op_q.is_read);
    assign bus_oe_n = !((ph == PH_STROBE) && op_q.is_read);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!bus_we_n && !bus_oe_n));

    // R4
    strobe_ce_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_we_n || !bus_oe_n) |-> !bus_ce_n);

    // R5
    drive_oe_chk: assert property (@(posedge clk) disable iff (rst)
        bus_doe |-> bus_oe_n);

endmodule

// File: rtl/flash_toggle_mon.sv
module flash_toggle_mon #(
    parameter int POLL_LIMIT = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic sample,
    input  logic bit_in,
    output logic settled,
    output logic expired
);

    localparam int CW = $clog2(POLL_LIMIT + 1);

    logic          seen;
    logic          prev;
    logic [CW-1:0] n_reads;

    assign settled = sample && seen && (bit_in == prev);
    assign expired = sample && !settled && (n_reads == CW'(POLL_LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            seen    <= 1'b0;
            prev    <= 1'b0;
            n_reads <= '0;
        end else if (sample) begin
            seen <= 1'b1;
            prev <= bit_in;
            if (n_reads != CW'(POLL_LIMIT)) n_reads <= n_reads + 1'b1;
        end
    end

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int SETUP_CLKS = 1,
    parameter int WE_CLKS    = 3,
    parameter int RD_CLKS    = 3,
    parameter int HOLD_CLKS  = 1,
    parameter int POLL_LIMIT = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    output logic              done,
    output logic              err_timeout,
    output logic              err_verify,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [7:0]        fl_dq_in,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n
);

    ctl_e              st;
    logic [1:0]        idx;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic              done_q, err_t_q, err_v_q;

    logic              phy_start, phy_fin;
    bus_op_t           phy_op;
    logic [ADDR_W-1:0] phy_addr;
    logic [7:0]        phy_rdata;
    logic              poll_settled, poll_expired;

    assign req_ready = (st == CS_IDLE);
    assign phy_start = (st == CS_WR_GO) || (st == CS_POLL_GO) || (st == CS_CHK_GO);

    always_comb begin
        phy_op.is_read = (st != CS_WR_GO);
        phy_op.wdata   = (idx == 2'd3) ? data_q : cmd_data(idx);
        if (st == CS_WR_GO && idx != 2'd3) phy_addr = ADDR_W'(cmd_addr(idx));
        else                               phy_addr = addr_q;
    end

    flash_bus_phy #(
        .ADDR_W(ADDR_W), .SETUP_CLKS(SETUP_CLKS), .WE_CLKS(WE_CLKS),
        .RD_CLKS(RD_CLKS), .HOLD_CLKS(HOLD_CLKS)
    ) u_phy (
        .clk(clk), .rst(rst), .start(phy_start), .op(phy_op), .addr(phy_addr),
        .fin(phy_fin), .rdata(phy_rdata),
        .bus_addr(fl_addr), .bus_dout(fl_dq_out), .bus_doe(fl_dq_oe),
        .bus_din(fl_dq_in), .bus_ce_n(fl_ce_n), .bus_oe_n(fl_oe_n), .bus_we_n(fl_we_n)
    );

    flash_toggle_mon #(.POLL_LIMIT(POLL_LIMIT)) u_mon (
        .clk(clk), .rst(rst),
        .clear(st == CS_IDLE),
        .sample((st == CS_POLL_WAIT) && phy_fin),
        .bit_in(phy_rdata[STATUS_BIT]),
        .settled(poll_settled),
        .expired(poll_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= CS_IDLE;
            idx     <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            done_q  <= 1'b0;
            err_t_q <= 1'b0;
            err_v_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                CS_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        data_q  <= req_data;
                        err_t_q <= 1'b0;
                        err_v_q <= 1'b0;
                        idx     <= '0;
                        st      <= CS_WR_GO;
                    end
                end
                CS_WR_GO: st <= CS_WR_WAIT;
                CS_WR_WAIT: begin
                    if (phy_fin) begin
                        if (idx == 2'd3) begin
                            st <= CS_POLL_GO;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= CS_WR_GO;
                        end
                    end
                end
                CS_POLL_GO: st <= CS_POLL_WAIT;
                CS_POLL_WAIT: begin
                    if (phy_fin) begin
                        if (poll_settled) begin
                            st <= CS_CHK_GO;
                        end else if (poll_expired) begin
                            err_t_q <= 1'b1;
                            done_q  <= 1'b1;
                            st      <= CS_IDLE;
                        end else begin
                            st <= CS_POLL_GO;
                        end
                    end
                end
                CS_CHK_GO: st <= CS_CHK_WAIT;
                CS_CHK_WAIT: begin
                    if (phy_fin) begin
                        err_v_q <= (phy_rdata != data_q);
                        done_q  <= 1'b1;
                        st      <= CS_IDLE;
                    end
                end
                default: st <= CS_IDLE;
            endcase
        end
    end

    assign done        = done_q;
    assign err_timeout = err_t_q;
    assign err_verify  = err_v_q;

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    tmo_done_chk: assert property (@(posedge clk) disable iff (rst)
        poll_expired |=> (done && err_timeout && req_ready));

    // R9
    err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(err_timeout && err_verify));

endmodule

// File: tb/tb_flash_prog_ctrl.sv
module tb_flash_prog_ctrl;

    localparam int AW  = 18;
    localparam int SU  = 2;
    localparam int WEC = 3;
    localparam int RDC = 2;
    localparam int HD  = 1;
    localparam int LIM = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          done, err_timeout, err_verify;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dq_out;
    logic          fl_dq_oe;
    logic [7:0]    fl_dq_in = 8'h00;
    logic          fl_ce_n, fl_oe_n, fl_we_n;

    flash_prog_ctrl #(
        .ADDR_W(AW), .SETUP_CLKS(SU), .WE_CLKS(WEC), .RD_CLKS(RDC),
        .HOLD_CLKS(HD), .POLL_LIMIT(LIM)
    ) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .done(done),
        .err_timeout(err_timeout), .err_verify(err_verify),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    typedef struct packed {
        logic          ce_n, we_n, oe_n, doe;
        logic [AW-1:0] addr;
        logic [7:0]    dout;
        logic          ready, done, et, ev;
    } vec_t;

    vec_t  expq[$];
    string tagq[$];
    int    vectors = 0;
    int    miscompares = 0;
    logic  cur_et = 1'b0, cur_ev = 1'b0;
    bit    finished = 1'b0;

    // behavioural flash
    int            tog_k = 0;
    logic [7:0]    store_val = 8'h00;
    logic [7:0]    mem_val = 8'hFF;
    bit            active = 1'b0;
    int            nreads = 0;
    logic          prev_we = 1'b1, prev_oe = 1'b1;
    logic [AW-1:0] ha [3];
    logic [7:0]    hd [3];

    always @(negedge clk) begin
        if (!prev_we && fl_we_n) begin
            if (ha[0] == AW'(18'h05555) && hd[0] == 8'hAA &&
                ha[1] == AW'(18'h02AAA) && hd[1] == 8'h55 &&
                ha[2] == AW'(18'h05555) && hd[2] == 8'hA0) begin
                active  = (tog_k != 0);
                nreads  = 0;
                mem_val = store_val;
                ha[0] = '0; ha[1] = '0; ha[2] = '0;
            end else begin
                ha[0] = ha[1]; hd[0] = hd[1];
                ha[1] = ha[2]; hd[1] = hd[2];
                ha[2] = fl_addr; hd[2] = fl_dq_out;
            end
        end
        if (!prev_oe && fl_oe_n && active) begin
            nreads++;
            if (nreads >= tog_k) active = 1'b0;
        end
        prev_we = fl_we_n;
        prev_oe = fl_oe_n;
        fl_dq_in = active ? {1'b0, nreads[0], nreads[5:0]} : mem_val;
    end

    function automatic vec_t idle_vec(logic rdy, logic dn, logic et, logic ev);
        vec_t v;
        v = '0;
        v.ce_n = 1'b1; v.we_n = 1'b1; v.oe_n = 1'b1; v.doe = 1'b0;
        v.ready = rdy; v.done = dn; v.et = et; v.ev = ev;
        return v;
    endfunction

    task automatic push(vec_t v, string tag);
        expq.push_back(v);
        tagq.push_back(tag);
    endtask

    // one bus access: gap cycle, setup, strobe, hold
    task automatic push_access(bit rd, logic [AW-1:0] a, logic [7:0] d);
        vec_t v;
        string tg;
        tg = rd ? "R5/R7" : "R3/R4";
        push(idle_vec(1'b0, 1'b0, 1'b0, 1'b0), "R6");
        v = idle_vec(1'b0, 1'b0, 1'b0, 1'b0);
        v.ce_n = 1'b0; v.addr = a; v.doe = !rd; v.dout = rd ? 8'h00 : d;
        for (int i = 0; i < SU; i++) push(v, tg);
        if (rd) v.oe_n = 1'b0; else v.we_n = 1'b0;
        for (int i = 0; i < (rd ? RDC : WEC); i++) push(v, tg);
        v.oe_n = 1'b1; v.we_n = 1'b1;
        for (int i = 0; i < HD; i++) push(v, tg);
    endtask

    function automatic logic bit_at(int r, int k, logic s6);
        return (r < k) ? logic'(r % 2) : s6;
    endfunction

    task automatic check_cycle();
        vec_t e, a;
        string tg;
        if (expq.size() > 0) begin
            e  = expq.pop_front();
            tg = tagq.pop_front();
        end else begin
            e  = idle_vec(1'b1, 1'b0, cur_et, cur_ev);
            tg = "R2/R10";
        end
        a.ce_n = fl_ce_n; a.we_n = fl_we_n; a.oe_n = fl_oe_n; a.doe = fl_dq_oe;
        a.addr = fl_addr; a.dout = fl_dq_out;
        a.ready = req_ready; a.done = done; a.et = err_timeout; a.ev = err_verify;
        if (e.ce_n) a.addr = '0;
        if (!e.doe) a.dout = '0;
        vectors++;
        if (a !== e) begin
            miscompares++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tg, $time, a, e);
        end
        cur_et = e.et;
        cur_ev = e.ev;
    endtask

    task automatic step();
        @(negedge clk);
        check_cycle();
    endtask

    task automatic run(logic [AW-1:0] a, logic [7:0] d, int k, logic [7:0] sv, bit poke);
        bit tmo;
        int nr;
        bit found;
        step();
        tog_k = k;
        store_val = sv;
        req_addr = a;
        req_data = d;
        req_valid = 1'b1;
        // R3: three command writes then the payload
        push_access(1'b0, AW'(18'h05555), 8'hAA);
        push_access(1'b0, AW'(18'h02AAA), 8'h55);
        push_access(1'b0, AW'(18'h05555), 8'hA0);
        push_access(1'b0, a, d);
        // R7 R8 R11: read count until bit 6 repeats
        found = 1'b0;
        nr = LIM;
        for (int r = 1; r < LIM; r++) begin
            if (!found && bit_at(r, k, sv[6]) == bit_at(r - 1, k, sv[6])) begin
                found = 1'b1;
                nr = r + 1;
            end
        end
        tmo = !found;
        for (int r = 0; r < nr; r++) push_access(1'b1, a, 8'h00);
        if (!tmo) push_access(1'b1, a, 8'h00);
        // R9 R10
        push(idle_vec(1'b1, 1'b1, tmo, !tmo && (sv != d)), tmo ? "R8/R10" : "R9/R10");
        step();
        req_valid = 1'b0;
        for (int c = 0; expq.size() > 0; c++) begin
            // R2: request raised while busy must be ignored
            if (poke && c == 3) begin
                req_valid = 1'b1;
                req_addr = ~a;
                req_data = ~d;
            end
            if (poke && c == 9) req_valid = 1'b0;
            step();
        end
        step();
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check_cycle();                  // R1 during reset
        rst = 1'b0;
        step();                         // R1 after release
        run(18'h31234, 8'hC3, 5, 8'hC3, 1'b0);  // R7 normal
        run(18'h00010, 8'h5A, 0, 8'h5A, 1'b0);  // immediately stable
        run(18'h2ABCD, 8'h00, 3, 8'h00, 1'b0);  // R11 low bits differ on match
        run(18'h1FFFF, 8'h81, 2, 8'h80, 1'b0);  // R9 verify mismatch
        run(18'h3FFFF, 8'h3C, 20, 8'h3C, 1'b0); // R8 timeout
        run(18'h20001, 8'hE7, 4, 8'hE7, 1'b1);  // R2 busy request ignored
        run(18'h00000, 8'h40, 1, 8'h40, 1'b0);  // toggle meets stored byte
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule